// File: doc/BRIEF.md
# Question-answer window watchdog

This block is an independent supervisor that checks whether a host processor is still executing its software correctly. Each service cycle starts with a closed phase and is followed by an open phase. The block presents a 4-bit question that the host reads. The host must then write back an 8-bit answer, computed from the question by a fixed function, while the open phase is running. An answer written during the closed phase is a fault. A wrong answer is a fault. An open phase that ends with no answer is also a fault.

Faults raise a small error count and correct answers lower it. When a fault brings the count up to a configured limit, the block drives a host reset output for a fixed number of cycles. After that pulse the count, the question generator and the phase timer all start again from their initial values. The host reaches the block through a plain register-style write/read port, which stands in for a serial bus. The lengths of both phases and the error limit are static configuration inputs.

Top module: `qawd_top`

## Requirements
- R1: After `rst_n` is released, the question register (read address 0, bits [3:0]) holds 4'h1. The status register (read address 2) reads 8'h00. `host_rst` is low and the block is in the closed phase.
- R2: A service cycle stays in the closed phase for `cfg_closed_len` cycles and then in the open phase for at most `cfg_open_len` cycles. A length of 0 acts as 1. Status bit 5 is 1 while the open phase runs.
- R3: A write to the answer address (write address 1) during the closed phase is an early fault. It sets status bits [1:0] to 1, adds one to the error count, leaves the question unchanged and restarts the closed phase from its first cycle.
- R4: A write during the open phase whose data equals ({q, ~q} XOR 8'hA5), with q the current question, is a correct answer. It lowers the error count by one, or leaves it at zero, advances the question, and starts a new closed phase.
- R5: Any other data written during the open phase is a wrong-answer fault. It sets status bits [1:0] to 3, adds one to the error count, keeps the same question, and starts a new closed phase.
- R6: If the open phase ends with no answer, that is a late fault. It sets status bits [1:0] to 2, adds one to the error count, keeps the same question, and starts a new closed phase.
- R7: If a fault brings the error count (status bits [4:2]) to `cfg_err_limit` or above, `host_rst` goes high from the next cycle for exactly 16 cycles. A limit of 0 acts as 1.
- R8: While `host_rst` is high, answer writes have no effect. After the pulse the error count is 0, the question is 4'h1, and a full closed phase begins. Status bits [1:0] keep the last fault type.
- R9: The question advances by shifting left one bit and feeding back q[3] XOR q[2] into bit 0. This walks through all 15 nonzero values before it repeats.
- R10: Reads from address 1 and address 3 return 0. Status bits [7:6] read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_closed_len | input | CNT_W | Closed phase length in cycles |
| cfg_open_len | input | CNT_W | Open phase length in cycles |
| cfg_err_limit | input | 3 | Error count that trips the host reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address; 1 is the answer register |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address; 0 question, 2 status |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| host_rst | output | 1 | Reset request to the host, high for 16 cycles |

## Verification
The phase timer is swept over every pair of closed and open lengths from 1 to 3 with no answer written. This measures both phases cycle by cycle and shows that a silent host gives a late fault. A run of correct answers, each written at a different offset inside the open window, walks the question through its full 15-value period. The same run shows that the error count stops at zero. Early, wrong and late answers are then compared for their distinct status codes, their effect on the question and the restart point of the timer. Answers written during the reset pulse, and a limit of 0, separate the trip point, the pulse width and the return to the initial state.

// File: rtl/qawd_pkg.sv
package qawd_pkg;

  // Fault codes reported in status bits [1:0]
  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_EARLY = 2'd1,
    FLT_LATE  = 2'd2,
    FLT_WRONG = 2'd3
  } fault_e;

  localparam int          Q_W       = 4;
  localparam int          ANS_W     = 8;
  localparam int          ERR_W     = 3;
  localparam logic [3:0]  Q_INIT    = 4'h1;
  localparam logic [7:0]  ANS_MASK  = 8'hA5;

  localparam logic [1:0]  ADDR_QUESTION = 2'd0;
  localparam logic [1:0]  ADDR_ANSWER   = 2'd1;
  localparam logic [1:0]  ADDR_STATUS   = 2'd2;

  // Answer the host must return for question q
  function automatic logic [ANS_W-1:0] expected_answer(input logic [Q_W-1:0] q);
    return {q, ~q} ^ ANS_MASK;
  endfunction

  // One step of the 4-bit maximal-length question sequence
  function automatic logic [Q_W-1:0] question_step(input logic [Q_W-1:0] q);
    return {q[2:0], q[3] ^ q[2]};
  endfunction

endpackage

// File: rtl/qawd_window_timer.sv
module qawd_window_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] cfg_closed_len,
  input  logic [CNT_W-1:0] cfg_open_len,
  input  logic             ans_wr,
  output logic             phase_open,
  output logic             ev_early,
  output logic             ev_late,
  output logic             ev_answered
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_closed;
  logic [CNT_W-1:0] last_open;
  logic             at_end;

  // A zero length behaves as a one-cycle phase
  assign last_closed = (cfg_closed_len == '0) ? '0 : cfg_closed_len - CNT_W'(1);
  assign last_open   = (cfg_open_len   == '0) ? '0 : cfg_open_len   - CNT_W'(1);
  assign at_end      = (cnt == (phase_open ? last_open : last_closed));

  assign ev_early    = ans_wr && !phase_open;
  assign ev_answered = ans_wr && phase_open;
  assign ev_late     = phase_open && at_end && !ans_wr;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      phase_open <= 1'b0;
      cnt        <= '0;
    end else if (ev_early) begin
      cnt        <= '0;
    end else if (ev_answered || ev_late) begin
      phase_open <= 1'b0;
      cnt        <= '0;
    end else if (at_end) begin
      phase_open <= 1'b1;
      cnt        <= '0;
    end else begin
      cnt        <= cnt + CNT_W'(1);
    end
  end

  AST_EARLY_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n) (ev_early && !clr) |=> (!phase_open && cnt == '0)); // R3
  AST_LATE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n) (ev_late && !clr) |=> (!phase_open && cnt == '0)); // R6
  AST_ANSWER_CLOSES: assert property (@(posedge clk) disable iff (!rst_n) (ev_answered && !clr) |=> !phase_open); // R4
  AST_OPENS_AFTER_CLOSED: assert property (@(posedge clk) disable iff (!rst_n) (!phase_open && at_end && !ans_wr && !clr) |=> phase_open); // R2

endmodule

// File: rtl/qawd_question_gen.sv
module qawd_question_gen
  import qawd_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           adv,
  output logic [Q_W-1:0] question
);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      question <= Q_INIT;
    end else if (adv) begin
      question <= question_step(question);
    end
  end

  AST_Q_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!adv && !clr) |=> $stable(question)); // R5
  AST_Q_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) question != '0); // R9

endmodule

// File: rtl/qawd_fault_ctrl.sv
module qawd_fault_ctrl
  import qawd_pkg::*;
#(
  parameter int RST_LEN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_early,
  input  logic             ev_late,
  input  logic             ev_wrong,
  input  logic             ev_good,
  input  logic [ERR_W-1:0] cfg_err_limit,
  output logic [ERR_W-1:0] err_cnt,
  output fault_e           last_fault,
  output logic             trip,
  output logic             host_rst
);

  localparam int PW = $clog2(RST_LEN + 1) + 1;

  logic [PW-1:0]    pulse_cnt;
  logic [ERR_W-1:0] cnt_inc;
  logic [ERR_W-1:0] limit_eff;
  logic             any_fault;

  assign any_fault = ev_early || ev_late || ev_wrong;
  assign cnt_inc   = (err_cnt == '1) ? err_cnt : err_cnt + ERR_W'(1);
  assign limit_eff = (cfg_err_limit == '0) ? ERR_W'(1) : cfg_err_limit;
  assign trip      = any_fault && (cnt_inc >= limit_eff);
  assign host_rst  = (pulse_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_cnt   <= '0;
      pulse_cnt <= '0;
    end else if (trip) begin
      err_cnt   <= '0;
      pulse_cnt <= PW'(RST_LEN);
    end else if (host_rst) begin
      err_cnt   <= '0;
      pulse_cnt <= pulse_cnt - PW'(1);
    end else if (any_fault) begin
      err_cnt   <= cnt_inc;
    end else if (ev_good && err_cnt != '0) begin
      err_cnt   <= err_cnt - ERR_W'(1);
    end
  end

  // The last fault type survives the watchdog reset pulse
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_fault <= FLT_NONE;
    end else if (ev_early) begin
      last_fault <= FLT_EARLY;
    end else if (ev_late) begin
      last_fault <= FLT_LATE;
    end else if (ev_wrong) begin
      last_fault <= FLT_WRONG;
    end
  end

  // Length of the current high stretch of host_rst, for the width check
  logic [PW-1:0] hi_len;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_len <= '0;
    end else if (host_rst) begin
      hi_len <= hi_len + PW'(1);
    end else begin
      hi_len <= '0;
    end
  end

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({ev_early, ev_late, ev_wrong, ev_good})); // R3
  AST_FAULT_INC: assert property (@(posedge clk) disable iff (!rst_n) (any_fault && !trip && !host_rst) |=> err_cnt == $past(err_cnt) + ERR_W'(1)); // R5
  AST_GOOD_DEC: assert property (@(posedge clk) disable iff (!rst_n) (ev_good && err_cnt != '0 && !host_rst) |=> err_cnt == $past(err_cnt) - ERR_W'(1)); // R4
  AST_GOOD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n) (ev_good && err_cnt == '0 && !host_rst) |=> err_cnt == '0); // R4
  AST_TRIP_PULSE: assert property (@(posedge clk) disable iff (!rst_n) trip |=> host_rst); // R7
  AST_RST_MAX: assert property (@(posedge clk) disable iff (!rst_n) hi_len <= PW'(RST_LEN)); // R7
  AST_RST_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(host_rst) |-> hi_len == PW'(RST_LEN)); // R7
  AST_QUIET_IN_RST: assert property (@(posedge clk) disable iff (!rst_n) host_rst |-> !(any_fault || ev_good)); // R8

endmodule

// File: rtl/qawd_top.sv
module qawd_top
  import qawd_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int RST_LEN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_closed_len,
  input  logic [CNT_W-1:0] cfg_open_len,
  input  logic [2:0]       cfg_err_limit,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [1:0]       rd_addr,
  output logic [7:0]       rd_data,
  output logic             host_rst
);

  // Named internal events, kept visible for the assertions
  logic             ans_wr;
  logic             phase_open;
  logic             ev_early;
  logic             ev_late;
  logic             ev_answered;
  logic             ev_good;
  logic             ev_wrong;
  logic             trip;
  logic             hold;
  logic [Q_W-1:0]   question;
  logic [ERR_W-1:0] err_cnt;
  fault_e           last_fault;

  assign ans_wr   = wr_en && (wr_addr == ADDR_ANSWER) && !host_rst;
  assign ev_good  = ev_answered && (wr_data == expected_answer(question));
  assign ev_wrong = ev_answered && !ev_good;
  assign hold     = trip || host_rst;

  qawd_window_timer #(.CNT_W(CNT_W)) u_timer (
    .clk            (clk),
    .rst_n          (rst_n),
    .clr            (hold),
    .cfg_closed_len (cfg_closed_len),
    .cfg_open_len   (cfg_open_len),
    .ans_wr         (ans_wr),
    .phase_open     (phase_open),
    .ev_early       (ev_early),
    .ev_late        (ev_late),
    .ev_answered    (ev_answered)
  );

  qawd_question_gen u_qgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (hold),
    .adv      (ev_good),
    .question (question)
  );

  qawd_fault_ctrl #(.RST_LEN(RST_LEN)) u_fault (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_early      (ev_early),
    .ev_late       (ev_late),
    .ev_wrong      (ev_wrong),
    .ev_good       (ev_good),
    .cfg_err_limit (cfg_err_limit),
    .err_cnt       (err_cnt),
    .last_fault    (last_fault),
    .trip          (trip),
    .host_rst      (host_rst)
  );

  always_comb begin
    case (rd_addr)
      ADDR_QUESTION: rd_data = {4'h0, question};
      ADDR_STATUS:   rd_data = {2'b00, phase_open, err_cnt, last_fault};
      default:       rd_data = 8'h00;
    endcase
  end

  AST_GOOD_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n) (ev_good && !hold) |=> question == question_step($past(question))); // R4
  AST_EARLY_KEEPS_Q: assert property (@(posedge clk) disable iff (!rst_n) (ev_early && !hold) |=> $stable(question)); // R3
  AST_RST_BLOCKS_WR: assert property (@(posedge clk) disable iff (!rst_n) host_rst |-> !ans_wr); // R8
  AST_POST_PULSE: assert property (@(posedge clk) disable iff (!rst_n) $fell(host_rst) |-> (question == Q_INIT && err_cnt == '0 && !phase_open)); // R8

endmodule

// File: tb/qawd_top_bench.sv
module qawd_top_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_closed_len = 8'd2;
  logic [7:0] cfg_open_len = 8'd3;
  logic [2:0] cfg_err_limit = 3'd7;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic       host_rst;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  qawd_top u_qawd_top (
    .clk (clk), .rst_n (rst_n),
    .cfg_closed_len (cfg_closed_len), .cfg_open_len (cfg_open_len),
    .cfg_err_limit (cfg_err_limit),
    .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
    .rd_addr (rd_addr), .rd_data (rd_data), .host_rst (host_rst)
  );

  // Bench-side arithmetic, written independently of the design
  function automatic int ans_of(input int q);
    return ((q * 16) + (15 - q)) ^ 165;
  endfunction

  function automatic int next_q(input int q);
    return ((q << 1) & 15) | (((q >> 3) ^ (q >> 2)) & 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic do_reset(input int c, input int o, input int l);
    wr_en = 1'b0;
    rst_n = 1'b0;
    cfg_closed_len = 8'(c);
    cfg_open_len = 8'(o);
    cfg_err_limit = 3'(l);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Counts negedges while the phase bit equals want; returns at the first other value
  task automatic phase_len(input bit want, output int n);
    int s;
    n = 0;
    rd(2'd2, s);
    while (((s >> 5) & 1) == int'(want) && n < 300) begin
      n++;
      @(negedge clk);
      rd(2'd2, s);
    end
  endtask

  task automatic write_ans(input int v);
    wr_en = 1'b1;
    wr_addr = 2'd1;
    wr_data = 8'(v);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_open();
    int s;
    int n;
    n = 0;
    rd(2'd2, s);
    while (((s >> 5) & 1) == 0 && n < 300) begin
      n++;
      @(negedge clk);
      rd(2'd2, s);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int s, v, n, qm, cm;

    // R1: reset state
    do_reset(2, 3, 7);
    rd(2'd0, v); check(v == 1, "R1 question", v, 1);
    rd(2'd2, v); check(v == 0, "R1 status", v, 0);
    check(host_rst == 1'b0, "R1 host_rst", int'(host_rst), 0);
    // R10: unused read addresses
    rd(2'd1, v); check(v == 0, "R10 addr1", v, 0);
    rd(2'd3, v); check(v == 0, "R10 addr3", v, 0);

    // R2 / R6: sweep of phase lengths with no answer
    for (int c = 1; c <= 3; c++) begin
      for (int o = 1; o <= 3; o++) begin
        do_reset(c, o, 7);
        phase_len(1'b0, n); check(n == c, "R2 closed length", n, c);
        phase_len(1'b1, n); check(n == o, "R2 open length", n, o);
        rd(2'd2, s);
        check((s & 3) == 2, "R6 late code", s & 3, 2);
        check(((s >> 2) & 7) == 1, "R6 count", (s >> 2) & 7, 1);
        rd(2'd0, v); check(v == 1, "R6 question kept", v, 1);
      end
    end

    // R2: zero length acts as one
    do_reset(0, 0, 7);
    phase_len(1'b0, n); check(n == 1, "R2 zero closed", n, 1);
    phase_len(1'b1, n); check(n == 1, "R2 zero open", n, 1);

    // R4 / R9: correct answers walk the full question period, count floors at zero
    do_reset(2, 3, 7);
    phase_len(1'b0, n);
    phase_len(1'b1, n);            // one late fault, count = 1
    qm = 1;
    cm = 1;
    for (int i = 0; i < 15; i++) begin
      wait_open();
      repeat (i % 3) @(negedge clk);
      write_ans(ans_of(qm));
      qm = next_q(qm);
      cm = (cm > 0) ? cm - 1 : 0;
      rd(2'd0, v); check(v == qm, "R9 question step", v, qm);
      rd(2'd2, s);
      check(((s >> 2) & 7) == cm, "R4 count floor", (s >> 2) & 7, cm);
      check(((s >> 5) & 1) == 0, "R4 new closed phase", (s >> 5) & 1, 0);
    end
    check(qm == 1, "R9 period 15", qm, 1);

    // R5: wrong answer
    wait_open();
    write_ans(ans_of(qm) ^ 1);
    rd(2'd2, s);
    check((s & 3) == 3, "R5 wrong code", s & 3, 3);
    check(((s >> 2) & 7) == 1, "R5 count", (s >> 2) & 7, 1);
    rd(2'd0, v); check(v == qm, "R5 question kept", v, qm);

    // R3: early answer, even with the correct value
    write_ans(ans_of(qm));
    rd(2'd2, s);
    check((s & 3) == 1, "R3 early code", s & 3, 1);
    check(((s >> 2) & 7) == 2, "R3 count", (s >> 2) & 7, 2);
    rd(2'd0, v); check(v == qm, "R3 question kept", v, qm);
    phase_len(1'b0, n); check(n == 2, "R3 closed restart", n, 2);

    // R7 / R8: limit 3 trips, pulse width, writes ignored, return to initial state
    do_reset(2, 3, 3);
    wait_open();
    write_ans(ans_of(1));          // question moves to 2
    for (int k = 0; k < 3; k++) begin
      wait_open();
      rd(2'd0, v);
      write_ans(ans_of(v) ^ 8'h10);
      if (k < 2) check(host_rst == 1'b0, "R7 below limit", int'(host_rst), 0);
    end
    check(host_rst == 1'b1, "R7 trip", int'(host_rst), 1);
    n = 0;
    while (host_rst && n < 40) begin
      if (n == 2) begin
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'(ans_of(1));
      end else begin
        wr_en = 1'b0;
      end
      n++;
      @(negedge clk);
    end
    wr_en = 1'b0;
    check(n == 16, "R7 pulse width", n, 16);
    rd(2'd2, s);
    check(((s >> 2) & 7) == 0, "R8 count cleared", (s >> 2) & 7, 0);
    check((s & 3) == 3, "R8 fault kept", s & 3, 3);
    rd(2'd0, v); check(v == 1, "R8 question initial", v, 1);
    phase_len(1'b0, n); check(n == 2, "R8 full closed phase", n, 2);

    // R7: limit 0 acts as 1
    do_reset(2, 3, 0);
    wait_open();
    write_ans(0);
    check(host_rst == 1'b1, "R7 limit zero", int'(host_rst), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule